// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a small processor core. Architectural registers 8 to 15 have one physical copy that every mode sees. Registers 0 to 7 have two physical copies, called bank 0 and bank 1. Which copy an ordinary access reaches depends on two things: the privilege level and a bank-select bit. Ordinary instructions use two combinational read ports and one write port, and these always address the architectural view.

A separate alternate port reaches the lower bank that is currently hidden. Privileged code uses it to save and restore the other context, as the load-to-control and store-from-control operations do. In user mode the alternate port is blocked: a write through it does nothing, a read returns zero, and a one-cycle violation flag tells the surrounding core that the access was refused.

The mode and bank-select inputs are captured in registers inside the block. A change therefore redirects accesses from the cycle after the clock edge that captured it. Instruction decode, the pipeline and exception sequencing stay with the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: Architectural registers 8 to 15 (4-bit address values 8..15) have one shared 32-bit copy each, and every combination of mode and bank bit returns the same value for them.
- R2: In user mode (`priv_mode` = 0), addresses 0..7 on the ordinary ports reach bank 0 whatever `bank_sel` holds.
- R3: In privileged mode (`priv_mode` = 1), addresses 0..7 on the ordinary ports reach bank 1 when `bank_sel` = 1 and bank 0 when `bank_sel` = 0.
- R4: In privileged mode, the 3-bit alternate address selects entry 0..7 of the bank that the ordinary ports do not currently map: bank 0 when `bank_sel` = 1, and bank 1 when `bank_sel` = 0.
- R5: In user mode an alternate write changes no entry in either bank, and `alt_rd_data` reads as zero.
- R6: `access_viol` is 1 in the cycle after a cycle in which `alt_rd_en` or `alt_wr_en` was asserted in user mode, and 0 in every other cycle.
- R7: Reads are combinational. A write commits at the rising clock edge, so a read of the same entry in the same cycle returns the old value and the new value shows after the edge.
- R8: `priv_mode` and `bank_sel` are registered. A change redirects accesses only after the next rising edge. After reset the block behaves as user mode with the bank bit at 0.
- R9: An active-low reset clears every entry of both banks and the shared half to zero, and it clears `access_viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| bank_sel | input | 1 | Bank-select bit, honoured only in privileged mode |
| rd_addr_a | input | 4 | Architectural address, read port A |
| rd_data_a | output | 32 | Read data, port A |
| rd_addr_b | input | 4 | Architectural address, read port B |
| rd_data_b | output | 32 | Read data, port B |
| wr_en | input | 1 | Ordinary write enable |
| wr_addr | input | 4 | Ordinary write address |
| wr_data | input | 32 | Ordinary write data |
| alt_rd_en | input | 1 | Alternate-bank read request |
| alt_rd_addr | input | 3 | Entry within the unmapped bank to read |
| alt_rd_data | output | 32 | Alternate read data, zero in user mode |
| alt_wr_en | input | 1 | Alternate-bank write request |
| alt_wr_addr | input | 3 | Entry within the unmapped bank to write |
| alt_wr_data | input | 32 | Alternate write data |
| access_viol | output | 1 | One-cycle pulse after a refused alternate access |

## Verification
Four properties are checked on every cycle. The violation flag pulses exactly when a user-mode alternate request was made one cycle earlier, and stays low otherwise. The alternate read data is zero in user mode. The internal mode register follows the mode input with one cycle of delay. Read data holds still while no write occurs and the address and mapping are unchanged. The mapping itself is shown only by the bench scenarios: each bank and the shared half are written with distinct values and read back under every combination of mode and bank bit. The same scenarios cover the untouched bank after a blocked write, the old-value read during a same-cycle write, and the one-cycle delay on a bank switch.

// File: rtl/brf_pkg.sv
package brf_pkg;
   typedef enum logic {
      MODE_USER = 1'b0,
      MODE_PRIV = 1'b1
   } brf_mode_e;
endpackage

// File: rtl/brf_bank_ctl.sv
// Holds the registered mode and bank bit, derives which lower bank is
// mapped and which is reachable through the alternate port, and raises
// the one-cycle violation flag for user-mode alternate requests.
module brf_bank_ctl
   import brf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      priv_mode,
   input  logic      bank_sel,
   input  logic      alt_req,
   output brf_mode_e mode_q,
   output logic      bank_q,
   output logic      map_bank,
   output logic      alt_bank,
   output logic      alt_ok,
   output logic      viol_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_USER;
         bank_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         mode_q <= priv_mode ? MODE_PRIV : MODE_USER;
         bank_q <= bank_sel;
         viol_q <= alt_req && (mode_q == MODE_USER);
      end
   end

   always_comb begin
      alt_ok   = (mode_q == MODE_PRIV);
      map_bank = alt_ok & bank_q;
      alt_bank = ~map_bank;
   end
endmodule

// File: rtl/brf_addr_map.sv
// Translates an architectural register index plus a bank choice into a
// physical storage index. Physical layout: 0..NUM_ARCH-1 hold bank 0 and
// the shared registers; NUM_ARCH.. hold the bank-1 copies.
module brf_addr_map #(
   parameter int NUM_ARCH   = 16,
   parameter int NUM_BANKED = 8,
   parameter int AW         = $clog2(NUM_ARCH),
   parameter int PW         = $clog2(NUM_ARCH + NUM_BANKED)
) (
   input  logic [AW-1:0] arch_idx,
   input  logic          bank,
   output logic [PW-1:0] phys_idx
);
   localparam int BASE1 = NUM_ARCH;

   always_comb begin
      if (bank && (int'(arch_idx) < NUM_BANKED))
         phys_idx = PW'(BASE1 + int'(arch_idx));
      else
         phys_idx = PW'(arch_idx);
   end
endmodule

// File: rtl/brf_storage.sv
// Flop-based storage with NWR write ports and NRD combinational read ports.
// Later write ports take priority when two address the same entry.
module brf_storage #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 24,
   parameter int NRD    = 3,
   parameter int NWR    = 2,
   parameter int PW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we    [NWR],
   input  logic [PW-1:0]     waddr [NWR],
   input  logic [DATA_W-1:0] wdata [NWR],
   input  logic [PW-1:0]     raddr [NRD],
   output logic [DATA_W-1:0] rdata [NRD]
);
   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[e] <= '0;
         end else begin
            for (int w = 0; w < NWR; w++) begin
               if (we[w] && (int'(waddr[w]) == e))
                  mem[e] <= wdata[w];
            end
         end
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      always_comb begin
         if (int'(raddr[r]) < DEPTH)
            rdata[r] = mem[raddr[r]];
         else
            rdata[r] = '0;
      end
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import brf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_ARCH   = 16,
   parameter int NUM_BANKED = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        priv_mode,
   input  logic                        bank_sel,
   input  logic [$clog2(NUM_ARCH)-1:0] rd_addr_a,
   output logic [DATA_W-1:0]           rd_data_a,
   input  logic [$clog2(NUM_ARCH)-1:0] rd_addr_b,
   output logic [DATA_W-1:0]           rd_data_b,
   input  logic                        wr_en,
   input  logic [$clog2(NUM_ARCH)-1:0] wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic                        alt_rd_en,
   input  logic [$clog2(NUM_BANKED)-1:0] alt_rd_addr,
   output logic [DATA_W-1:0]           alt_rd_data,
   input  logic                        alt_wr_en,
   input  logic [$clog2(NUM_BANKED)-1:0] alt_wr_addr,
   input  logic [DATA_W-1:0]           alt_wr_data,
   output logic                        access_viol
);
   localparam int AW    = $clog2(NUM_ARCH);
   localparam int BW    = $clog2(NUM_BANKED);
   localparam int DEPTH = NUM_ARCH + NUM_BANKED;
   localparam int PW    = $clog2(DEPTH);
   localparam int NRD   = 3;
   localparam int NWR   = 2;

   if (NUM_BANKED < 1 || NUM_BANKED > NUM_ARCH) begin : g_bad_bank
      $error("NUM_BANKED must lie between 1 and NUM_ARCH");
   end
   if ((1 << AW) != NUM_ARCH || (1 << BW) != NUM_BANKED) begin : g_bad_pow2
      $error("NUM_ARCH and NUM_BANKED must be powers of two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   brf_mode_e mode_q;
   logic      bank_q;
   logic      map_bank, alt_bank, alt_ok;

   brf_bank_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .priv_mode(priv_mode),
      .bank_sel (bank_sel),
      .alt_req  (alt_rd_en | alt_wr_en),
      .mode_q   (mode_q),
      .bank_q   (bank_q),
      .map_bank (map_bank),
      .alt_bank (alt_bank),
      .alt_ok   (alt_ok),
      .viol_q   (access_viol)
   );

   // Ports mapped: 0 = read A, 1 = read B, 2 = write, 3 = alt read, 4 = alt write
   localparam int NMAP = 5;
   logic [AW-1:0] map_arch [NMAP];
   logic          map_sel  [NMAP];
   logic [PW-1:0] map_phys [NMAP];

   always_comb begin
      map_arch[0] = rd_addr_a;
      map_arch[1] = rd_addr_b;
      map_arch[2] = wr_addr;
      map_arch[3] = AW'(alt_rd_addr);
      map_arch[4] = AW'(alt_wr_addr);
      map_sel[0]  = map_bank;
      map_sel[1]  = map_bank;
      map_sel[2]  = map_bank;
      map_sel[3]  = alt_bank;
      map_sel[4]  = alt_bank;
   end

   for (genvar m = 0; m < NMAP; m++) begin : g_map
      brf_addr_map #(
         .NUM_ARCH  (NUM_ARCH),
         .NUM_BANKED(NUM_BANKED),
         .AW        (AW),
         .PW        (PW)
      ) u_map (
         .arch_idx(map_arch[m]),
         .bank    (map_sel[m]),
         .phys_idx(map_phys[m])
      );
   end

   logic              st_we    [NWR];
   logic [PW-1:0]     st_waddr [NWR];
   logic [DATA_W-1:0] st_wdata [NWR];
   logic [PW-1:0]     st_raddr [NRD];
   logic [DATA_W-1:0] st_rdata [NRD];

   always_comb begin
      st_we[0]    = wr_en;
      st_waddr[0] = map_phys[2];
      st_wdata[0] = wr_data;
      st_we[1]    = alt_wr_en & alt_ok;
      st_waddr[1] = map_phys[4];
      st_wdata[1] = alt_wr_data;
      st_raddr[0] = map_phys[0];
      st_raddr[1] = map_phys[1];
      st_raddr[2] = map_phys[3];
   end

   brf_storage #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH),
      .NRD   (NRD),
      .NWR   (NWR),
      .PW    (PW)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (st_we),
      .waddr(st_waddr),
      .wdata(st_wdata),
      .raddr(st_raddr),
      .rdata(st_rdata)
   );

   always_comb begin
      rd_data_a   = st_rdata[0];
      rd_data_b   = st_rdata[1];
      alt_rd_data = alt_ok ? st_rdata[2] : '0;
   end
endmodule

// File: rtl/brf_chk.sv
module brf_chk #(
   parameter int DATA_W = 32,
   parameter int AW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              priv_mode,
   input logic              alt_rd_en,
   input logic              alt_wr_en,
   input logic              wr_en,
   input logic [AW-1:0]     rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [DATA_W-1:0] alt_rd_data,
   input logic              access_viol,
   input logic              mode_q,
   input logic              bank_q
);
   // R6
   viol_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((alt_rd_en || alt_wr_en) && !mode_q) |=> access_viol);

   // R6
   viol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((alt_rd_en || alt_wr_en) && !mode_q) |=> !access_viol);

   // R5
   alt_zero_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && alt_rd_en) |-> (alt_rd_data == '0));

   // R8
   mode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (mode_q == $past(priv_mode)));

   // R7
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !alt_wr_en) |=>
         (!($stable(rd_addr_a) && $stable(mode_q) && $stable(bank_q)) || $stable(rd_data_a)));
endmodule

bind banked_regfile brf_chk #(
   .DATA_W(DATA_W),
   .AW    (AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .priv_mode  (priv_mode),
   .alt_rd_en  (alt_rd_en),
   .alt_wr_en  (alt_wr_en),
   .wr_en      (wr_en),
   .rd_addr_a  (rd_addr_a),
   .rd_data_a  (rd_data_a),
   .alt_rd_data(alt_rd_data),
   .access_viol(access_viol),
   .mode_q     (mode_q),
   .bank_q     (bank_q)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
   localparam logic [1:0] OP_WR   = 2'd0;
   localparam logic [1:0] OP_AWR  = 2'd1;
   localparam logic [1:0] OP_RD   = 2'd2;
   localparam logic [1:0] OP_ARD  = 2'd3;

   typedef struct packed {
      logic        priv;
      logic        bank;
      logic [1:0]  op;
      logic [3:0]  addr;
      logic [31:0] data;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 17;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 1'b0, OP_WR,  4'd3, 32'hA000_0003, 4'd3}, // R3 bank0 r3
      '{1'b1, 1'b1, OP_WR,  4'd3, 32'hB100_0003, 4'd3}, // R3 bank1 r3
      '{1'b1, 1'b1, OP_WR,  4'd9, 32'h0000_0909, 4'd1}, // R1 shared r9
      '{1'b1, 1'b1, OP_RD,  4'd3, 32'hB100_0003, 4'd3}, // R3
      '{1'b1, 1'b0, OP_RD,  4'd3, 32'hA000_0003, 4'd3}, // R3
      '{1'b0, 1'b1, OP_RD,  4'd3, 32'hA000_0003, 4'd2}, // R2
      '{1'b0, 1'b0, OP_RD,  4'd9, 32'h0000_0909, 4'd1}, // R1
      '{1'b1, 1'b0, OP_RD,  4'd9, 32'h0000_0909, 4'd1}, // R1
      '{1'b1, 1'b0, OP_ARD, 4'd3, 32'hB100_0003, 4'd4}, // R4
      '{1'b1, 1'b1, OP_ARD, 4'd3, 32'hA000_0003, 4'd4}, // R4
      '{1'b1, 1'b1, OP_AWR, 4'd5, 32'hC000_0005, 4'd4}, // R4 into bank0 r5
      '{1'b1, 1'b0, OP_RD,  4'd5, 32'hC000_0005, 4'd4}, // R4
      '{1'b0, 1'b1, OP_RD,  4'd5, 32'hC000_0005, 4'd2}, // R2
      '{1'b0, 1'b0, OP_AWR, 4'd3, 32'hDEAD_0000, 4'd5}, // R5 blocked
      '{1'b1, 1'b1, OP_RD,  4'd3, 32'hB100_0003, 4'd5}, // R5
      '{1'b1, 1'b0, OP_RD,  4'd3, 32'hA000_0003, 4'd5}, // R5
      '{1'b0, 1'b0, OP_ARD, 4'd3, 32'h0000_0000, 4'd5}  // R5 reads zero
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv_mode = 1'b0, bank_sel = 1'b0;
   logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
   logic [31:0] rd_data_a, rd_data_b, alt_rd_data;
   logic        wr_en = 1'b0, alt_rd_en = 1'b0, alt_wr_en = 1'b0;
   logic [31:0] wr_data = '0, alt_wr_data = '0;
   logic [2:0]  alt_rd_addr = '0, alt_wr_addr = '0;
   logic        access_viol;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .bank_sel(bank_sel),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .alt_rd_en(alt_rd_en), .alt_rd_addr(alt_rd_addr), .alt_rd_data(alt_rd_data),
      .alt_wr_en(alt_wr_en), .alt_wr_addr(alt_wr_addr), .alt_wr_data(alt_wr_data),
      .access_viol(access_viol)
   );

   task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic set_mode(input logic p, input logic b);
      @(negedge clk);
      priv_mode = p;
      bank_sel  = b;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R9 / R8: reset state, user mode view all zero
      #1;
      check(9, "viol after reset", {31'd0, access_viol}, 32'd0);
      for (int i = 0; i < 16; i++) begin
         rd_addr_a = 4'(i);
         #1 check(9, "user view zero", rd_data_a, 32'd0);
      end
      // R9: bank1 cleared too
      set_mode(1'b1, 1'b1);
      for (int i = 0; i < 8; i++) begin
         rd_addr_a = 4'(i);
         #1 check(9, "bank1 zero", rd_data_a, 32'd0);
      end

      // Vector table walk
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         wr_en = 1'b0; alt_wr_en = 1'b0; alt_rd_en = 1'b0;
         set_mode(VECS[v].priv, VECS[v].bank);
         case (VECS[v].op)
            OP_WR: begin
               wr_en = 1'b1; wr_addr = VECS[v].addr; wr_data = VECS[v].data;
               @(negedge clk); wr_en = 1'b0;
            end
            OP_AWR: begin
               alt_wr_en = 1'b1; alt_wr_addr = VECS[v].addr[2:0]; alt_wr_data = VECS[v].data;
               @(negedge clk); alt_wr_en = 1'b0;
            end
            OP_RD: begin
               rd_addr_a = VECS[v].addr;
               #1 check(int'(VECS[v].req), $sformatf("vector %0d read", v), rd_data_a, VECS[v].data);
            end
            default: begin
               alt_rd_addr = VECS[v].addr[2:0];
               #1 check(int'(VECS[v].req), $sformatf("vector %0d alt read", v), alt_rd_data, VECS[v].data);
            end
         endcase
      end

      // R7: same-cycle write and read of the same entry returns old value
      set_mode(1'b1, 1'b0);
      wr_en = 1'b1; wr_addr = 4'd10; wr_data = 32'h0000_1111;
      @(negedge clk);
      wr_data = 32'h0000_2222; rd_addr_a = 4'd10; rd_addr_b = 4'd10;
      #1;
      check(7, "old value port A", rd_data_a, 32'h0000_1111);
      check(7, "old value port B", rd_data_b, 32'h0000_1111);
      @(negedge clk);
      wr_en = 1'b0;
      #1 check(7, "new value after edge", rd_data_a, 32'h0000_2222);

      // R6: violation pulse timing
      set_mode(1'b0, 1'b1);
      alt_rd_en = 1'b1; alt_rd_addr = 3'd3;
      #1 check(6, "viol before edge", {31'd0, access_viol}, 32'd0);
      @(negedge clk);
      alt_rd_en = 1'b0;
      check(6, "viol after attempt", {31'd0, access_viol}, 32'd1);
      @(negedge clk);
      check(6, "viol one cycle only", {31'd0, access_viol}, 32'd0);
      // R6: privileged alternate access raises nothing
      set_mode(1'b1, 1'b1);
      alt_wr_en = 1'b1; alt_wr_addr = 3'd6; alt_wr_data = 32'h0000_0066;
      @(negedge clk);
      alt_wr_en = 1'b0;
      check(6, "no viol in privileged", {31'd0, access_viol}, 32'd0);

      // R8: bank switch delayed by one edge
      rd_addr_a = 4'd3;
      #1 check(8, "bank1 before switch", rd_data_a, 32'hB100_0003);
      @(negedge clk);
      bank_sel = 1'b0;
      #1 check(8, "switch not yet applied", rd_data_a, 32'hB100_0003);
      @(negedge clk);
      check(8, "switch applied", rd_data_a, 32'hA000_0003);

      // R9: a second reset clears both banks
      do_reset();
      set_mode(1'b1, 1'b1);
      rd_addr_a = 4'd3;
      #1 check(9, "bank1 r3 cleared", rd_data_a, 32'd0);
      alt_rd_addr = 3'd5;
      #1 check(9, "bank0 r5 cleared", alt_rd_data, 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule